// File: doc/BRIEF.md
# Trace Reuse Memory

This block remembers dynamic instruction traces that have already run, so that a later fetch of the same start address can skip the whole trace. Each stored trace has a start address, a short list of live input locations with the values they held, a short list of output locations with their final values, and the address of the instruction that follows the trace. The table is set-associative. The low bits of the start address pick a set, and the remaining bits are kept as a tag. Several traces that begin at the same address can sit in different ways of one set.

The fetch side presents an address on the lookup port. One cycle later the block reports whether a reusable trace exists. On a hit it returns the redirect address and the output list, which the pipeline applies in place of fetching the trace. Every architectural write is shown on the snoop port. In valid-bit mode, a write to any location that an entry lists as an input kills that entry. In value-compare mode, the block instead tracks whether every listed input still holds its stored value. The insert port stores a newly collected trace. It fills a free way first and otherwise evicts the way reused least recently.

Top module: `trace_reuse_mem`

## Requirements
- R1: After reset no entry is valid, and every lookup misses.
- R2: A lookup asserted in cycle t is answered in cycle t+1. A lookup of a stored start address hits and returns the stored next address, the way number, and the output slots (used, kind, location, value) exactly as inserted.
- R3: The set is `lk_pc[IDX_W-1:0]` and the tag is the remaining upper bits. An address with the same set bits but a different tag misses.
- R4: Up to WAYS traces with the same start address are held in separate ways. When more than one way hits, the lowest-numbered way is reported.
- R5: With `test_mode`=0 (valid-bit mode), a write (`wr_is_mem` 1 = memory, 0 = register) whose kind and location equal a used input slot of an entry invalidates that entry. A write to another location, or to the same location number of the other kind, leaves the entry valid.
- R6: When an invalidating write and a lookup of the same entry occur in one cycle, the lookup reports a miss.
- R7: With `test_mode`=1 (value-compare mode), an entry hits only while every used input slot's latest snooped value equals its stored value. A differing write makes it miss, and writing the stored value back makes it hit again.
- R8: An insert fills the lowest-numbered invalid way of its set. If all ways are valid, it evicts the way whose last insert or hit is oldest. Both inserts and lookup hits mark a way as most recently used.
- R9: The response fields are all zero in any cycle that does not report a hit, and a hit is reported only in the cycle after `lk_en`.
- R10: A write snooped in the same cycle as an insert does not affect the newly inserted entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| test_mode | input | 1 | 0 = valid-bit reuse test, 1 = value-compare reuse test |
| lk_en | input | 1 | Lookup request |
| lk_pc | input | PC_W | Fetch address to look up |
| wr_en | input | 1 | Architectural write seen this cycle |
| wr_is_mem | input | 1 | 1 = memory location, 0 = register |
| wr_loc | input | LOC_W | Written location |
| wr_val | input | VAL_W | Written value |
| ins_en | input | 1 | Insert a trace |
| ins_pc | input | PC_W | Start address of the new trace |
| ins_next_pc | input | PC_W | Address following the new trace |
| ins_in_used | input | N_IN | Input slot used flags |
| ins_in_mem | input | N_IN | Input slot kind flags |
| ins_in_loc | input | N_IN*LOC_W | Input slot locations |
| ins_in_val | input | N_IN*VAL_W | Input slot values |
| ins_out_used | input | N_OUT | Output slot used flags |
| ins_out_mem | input | N_OUT | Output slot kind flags |
| ins_out_loc | input | N_OUT*LOC_W | Output slot locations |
| ins_out_val | input | N_OUT*VAL_W | Output slot values |
| rsp_hit | output | 1 | Reusable trace found |
| rsp_way | output | $clog2(WAYS) | Way that hit |
| rsp_next_pc | output | PC_W | Redirect address |
| rsp_out_used | output | N_OUT | Output slot used flags |
| rsp_out_mem | output | N_OUT | Output slot kind flags |
| rsp_out_loc | output | N_OUT*LOC_W | Output slot locations |
| rsp_out_val | output | N_OUT*VAL_W | Output slot values |

## Verification
The bench builds the block with four sets (IDX_W=2), four ways, two input and two output slots, 16-bit addresses and 16-bit values. The small set count makes aliasing addresses trivial to pick, so tag mismatch and several traces per set are easy to reach. Four ways can be filled in a few inserts, which lets a recency ordering be built by hand and the expected LRU victim be worked out exactly. Two input slots are enough to separate a listed location from the same number of the other kind.

// File: rtl/trm_pkg.sv
package trm_pkg;
    typedef enum logic {
        TEST_VALID  = 1'b0,
        TEST_VALUES = 1'b1
    } test_mode_e;
endpackage

// File: rtl/trm_snoop.sv
module trm_snoop #(
    parameter int N_IN  = 4,
    parameter int LOC_W = 8,
    parameter int VAL_W = 32
) (
    input  logic                        wr_en,
    input  logic                        wr_is_mem,
    input  logic [LOC_W-1:0]            wr_loc,
    input  logic [VAL_W-1:0]            wr_val,
    input  logic [N_IN-1:0]             in_used,
    input  logic [N_IN-1:0]             in_mem,
    input  logic [N_IN-1:0][LOC_W-1:0]  in_loc,
    input  logic [N_IN-1:0][VAL_W-1:0]  in_val,
    output logic [N_IN-1:0]             slot_hit,
    output logic [N_IN-1:0]             slot_same
);
    for (genvar i = 0; i < N_IN; i++) begin : g_slot
        assign slot_hit[i]  = wr_en && in_used[i] && (in_mem[i] == wr_is_mem)
                              && (in_loc[i] == wr_loc);
        assign slot_same[i] = (in_val[i] == wr_val);
    end
endmodule

// File: rtl/trm_hit_sel.sv
module trm_hit_sel #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  hit,
    output logic             found,
    output logic [WAY_W-1:0] way
);
    always_comb begin
        found = 1'b0;
        way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (hit[w]) begin
                found = 1'b1;
                way   = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/trm_victim.sv
module trm_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][WAY_W-1:0]  age,
    output logic [WAY_W-1:0]            pick
);
    logic [WAYS-1:0] oldest;
    logic            has_free;

    always_comb begin
        pick     = '0;
        has_free = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            oldest[w] = (age[w] == WAY_W'(WAYS - 1));
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid[w]) begin
                pick     = WAY_W'(w);
                has_free = 1'b1;
            end
        end
        if (!has_free) begin
            for (int w = 0; w < WAYS; w++) begin
                if (oldest[w]) pick = WAY_W'(w);
            end
        end
    end

    // R8
    lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(oldest) == 1);
endmodule

// File: rtl/trace_reuse_mem.sv
module trace_reuse_mem
    import trm_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 5,
    parameter int WAYS  = 4,
    parameter int N_IN  = 4,
    parameter int N_OUT = 4,
    parameter int LOC_W = 8,
    parameter int VAL_W = 32,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        test_mode,
    input  logic                        lk_en,
    input  logic [PC_W-1:0]             lk_pc,
    input  logic                        wr_en,
    input  logic                        wr_is_mem,
    input  logic [LOC_W-1:0]            wr_loc,
    input  logic [VAL_W-1:0]            wr_val,
    input  logic                        ins_en,
    input  logic [PC_W-1:0]             ins_pc,
    input  logic [PC_W-1:0]             ins_next_pc,
    input  logic [N_IN-1:0]             ins_in_used,
    input  logic [N_IN-1:0]             ins_in_mem,
    input  logic [N_IN-1:0][LOC_W-1:0]  ins_in_loc,
    input  logic [N_IN-1:0][VAL_W-1:0]  ins_in_val,
    input  logic [N_OUT-1:0]            ins_out_used,
    input  logic [N_OUT-1:0]            ins_out_mem,
    input  logic [N_OUT-1:0][LOC_W-1:0] ins_out_loc,
    input  logic [N_OUT-1:0][VAL_W-1:0] ins_out_val,
    output logic                        rsp_hit,
    output logic [WAY_W-1:0]            rsp_way,
    output logic [PC_W-1:0]             rsp_next_pc,
    output logic [N_OUT-1:0]            rsp_out_used,
    output logic [N_OUT-1:0]            rsp_out_mem,
    output logic [N_OUT-1:0][LOC_W-1:0] rsp_out_loc,
    output logic [N_OUT-1:0][VAL_W-1:0] rsp_out_val
);
    localparam int SETS    = 1 << IDX_W;
    localparam int ENTRIES = SETS * WAYS;
    localparam int TAG_W   = PC_W - IDX_W;

    typedef struct packed {
        logic                        valid;
        logic [TAG_W-1:0]            tag;
        logic [PC_W-1:0]             nxt;
        logic [WAY_W-1:0]            age;
        logic [N_IN-1:0]             in_used;
        logic [N_IN-1:0]             in_mem;
        logic [N_IN-1:0]             in_ok;
        logic [N_IN-1:0][LOC_W-1:0]  in_loc;
        logic [N_IN-1:0][VAL_W-1:0]  in_val;
        logic [N_OUT-1:0]            out_used;
        logic [N_OUT-1:0]            out_mem;
        logic [N_OUT-1:0][LOC_W-1:0] out_loc;
        logic [N_OUT-1:0][VAL_W-1:0] out_val;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0]        ent;
        logic                        hit;
        logic [WAY_W-1:0]            way;
        logic [PC_W-1:0]             nxt;
        logic [N_OUT-1:0]            o_used;
        logic [N_OUT-1:0]            o_mem;
        logic [N_OUT-1:0][LOC_W-1:0] o_loc;
        logic [N_OUT-1:0][VAL_W-1:0] o_val;
    } state_t;

    state_t st_d, st_q;
    test_mode_e mode;
    assign mode = test_mode_e'(test_mode);

    // Snoop comparison, one matcher per entry
    logic [ENTRIES-1:0][N_IN-1:0] snp_hit, snp_same;
    for (genvar e = 0; e < ENTRIES; e++) begin : g_snoop
        trm_snoop #(.N_IN(N_IN), .LOC_W(LOC_W), .VAL_W(VAL_W)) u_snoop (
            .wr_en     (wr_en),
            .wr_is_mem (wr_is_mem),
            .wr_loc    (wr_loc),
            .wr_val    (wr_val),
            .in_used   (st_q.ent[e].in_used),
            .in_mem    (st_q.ent[e].in_mem),
            .in_loc    (st_q.ent[e].in_loc),
            .in_val    (st_q.ent[e].in_val),
            .slot_hit  (snp_hit[e]),
            .slot_same (snp_same[e])
        );
    end

    // State of every entry after this cycle's snoop
    logic [ENTRIES-1:0]            eff_valid;
    logic [ENTRIES-1:0][N_IN-1:0]  eff_ok;
    logic [WAYS-1:0]               way_hit;
    logic [WAYS-1:0]               ins_valid_v;
    logic [WAYS-1:0][WAY_W-1:0]    ins_age_v;
    int                            lk_base, ins_base;

    always_comb begin
        lk_base  = int'(lk_pc[IDX_W-1:0]) * WAYS;
        ins_base = int'(ins_pc[IDX_W-1:0]) * WAYS;
        for (int e = 0; e < ENTRIES; e++) begin
            eff_ok[e] = st_q.ent[e].in_ok;
            for (int i = 0; i < N_IN; i++) begin
                if (snp_hit[e][i]) eff_ok[e][i] = snp_same[e][i];
            end
            eff_valid[e] = st_q.ent[e].valid && !(mode == TEST_VALID && |snp_hit[e]);
        end
        for (int w = 0; w < WAYS; w++) begin
            way_hit[w] = eff_valid[lk_base + w]
                && (st_q.ent[lk_base + w].tag == lk_pc[PC_W-1:IDX_W])
                && (mode == TEST_VALID
                    || &(eff_ok[lk_base + w] | ~st_q.ent[lk_base + w].in_used));
            ins_valid_v[w] = eff_valid[ins_base + w];
            ins_age_v[w]   = st_q.ent[ins_base + w].age;
        end
    end

    logic             lk_found;
    logic [WAY_W-1:0] lk_way;
    logic [WAY_W-1:0] ins_way;

    trm_hit_sel #(.WAYS(WAYS)) u_hit_sel (
        .hit   (way_hit),
        .found (lk_found),
        .way   (lk_way)
    );

    trm_victim #(.WAYS(WAYS)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (ins_valid_v),
        .age   (ins_age_v),
        .pick  (ins_way)
    );

    logic [WAY_W-1:0] ref_age;
    int               hit_e, new_e;

    always_comb begin
        st_d    = st_q;
        ref_age = '0;
        hit_e   = lk_base + int'(lk_way);
        new_e   = ins_base + int'(ins_way);
        for (int e = 0; e < ENTRIES; e++) begin
            st_d.ent[e].valid = eff_valid[e];
            st_d.ent[e].in_ok = eff_ok[e];
        end
        // lookup response
        st_d.hit    = lk_en && lk_found;
        st_d.way    = '0;
        st_d.nxt    = '0;
        st_d.o_used = '0;
        st_d.o_mem  = '0;
        st_d.o_loc  = '0;
        st_d.o_val  = '0;
        if (lk_en && lk_found) begin
            st_d.way    = lk_way;
            st_d.nxt    = st_q.ent[hit_e].nxt;
            st_d.o_used = st_q.ent[hit_e].out_used;
            st_d.o_mem  = st_q.ent[hit_e].out_mem;
            st_d.o_loc  = st_q.ent[hit_e].out_loc;
            st_d.o_val  = st_q.ent[hit_e].out_val;
            ref_age     = st_d.ent[hit_e].age;
            for (int w = 0; w < WAYS; w++) begin
                if (st_d.ent[lk_base + w].age < ref_age)
                    st_d.ent[lk_base + w].age = st_d.ent[lk_base + w].age + 1'b1;
            end
            st_d.ent[hit_e].age = '0;
        end
        // insert a new trace into the chosen way
        if (ins_en) begin
            st_d.ent[new_e].valid    = 1'b1;
            st_d.ent[new_e].tag      = ins_pc[PC_W-1:IDX_W];
            st_d.ent[new_e].nxt      = ins_next_pc;
            st_d.ent[new_e].in_used  = ins_in_used;
            st_d.ent[new_e].in_mem   = ins_in_mem;
            st_d.ent[new_e].in_ok    = '1;
            st_d.ent[new_e].in_loc   = ins_in_loc;
            st_d.ent[new_e].in_val   = ins_in_val;
            st_d.ent[new_e].out_used = ins_out_used;
            st_d.ent[new_e].out_mem  = ins_out_mem;
            st_d.ent[new_e].out_loc  = ins_out_loc;
            st_d.ent[new_e].out_val  = ins_out_val;
            ref_age = st_d.ent[new_e].age;
            for (int w = 0; w < WAYS; w++) begin
                if (st_d.ent[ins_base + w].age < ref_age)
                    st_d.ent[ins_base + w].age = st_d.ent[ins_base + w].age + 1'b1;
            end
            st_d.ent[new_e].age = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int e = 0; e < ENTRIES; e++) begin
                st_q.ent[e].age <= WAY_W'(e % WAYS);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_hit      = st_q.hit;
    assign rsp_way      = st_q.way;
    assign rsp_next_pc  = st_q.nxt;
    assign rsp_out_used = st_q.o_used;
    assign rsp_out_mem  = st_q.o_mem;
    assign rsp_out_loc  = st_q.o_loc;
    assign rsp_out_val  = st_q.o_val;

    // R1
    rst_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rsp_hit);

    // R9
    rsp_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(lk_en));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_next_pc == '0 && rsp_out_used == '0 && rsp_out_val == '0));
endmodule

// File: tb/trace_reuse_mem_test.sv
module trace_reuse_mem_test;
    localparam int PC_W = 16, IDX_W = 2, WAYS = 4, N_IN = 2, N_OUT = 2;
    localparam int LOC_W = 6, VAL_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_mode = 1'b0;
    logic lk_en = 1'b0;
    logic [PC_W-1:0] lk_pc = '0;
    logic wr_en = 1'b0, wr_is_mem = 1'b0;
    logic [LOC_W-1:0] wr_loc = '0;
    logic [VAL_W-1:0] wr_val = '0;
    logic ins_en = 1'b0;
    logic [PC_W-1:0] ins_pc = '0, ins_next_pc = '0;
    logic [N_IN-1:0] ins_in_used = '0, ins_in_mem = '0;
    logic [N_IN-1:0][LOC_W-1:0] ins_in_loc = '0;
    logic [N_IN-1:0][VAL_W-1:0] ins_in_val = '0;
    logic [N_OUT-1:0] ins_out_used = '0, ins_out_mem = '0;
    logic [N_OUT-1:0][LOC_W-1:0] ins_out_loc = '0;
    logic [N_OUT-1:0][VAL_W-1:0] ins_out_val = '0;
    logic rsp_hit;
    logic [1:0] rsp_way;
    logic [PC_W-1:0] rsp_next_pc;
    logic [N_OUT-1:0] rsp_out_used, rsp_out_mem;
    logic [N_OUT-1:0][LOC_W-1:0] rsp_out_loc;
    logic [N_OUT-1:0][VAL_W-1:0] rsp_out_val;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    trace_reuse_mem #(.PC_W(PC_W), .IDX_W(IDX_W), .WAYS(WAYS), .N_IN(N_IN),
        .N_OUT(N_OUT), .LOC_W(LOC_W), .VAL_W(VAL_W)) uut (
        .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
        .lk_en(lk_en), .lk_pc(lk_pc),
        .wr_en(wr_en), .wr_is_mem(wr_is_mem), .wr_loc(wr_loc), .wr_val(wr_val),
        .ins_en(ins_en), .ins_pc(ins_pc), .ins_next_pc(ins_next_pc),
        .ins_in_used(ins_in_used), .ins_in_mem(ins_in_mem),
        .ins_in_loc(ins_in_loc), .ins_in_val(ins_in_val),
        .ins_out_used(ins_out_used), .ins_out_mem(ins_out_mem),
        .ins_out_loc(ins_out_loc), .ins_out_val(ins_out_val),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_next_pc(rsp_next_pc),
        .rsp_out_used(rsp_out_used), .rsp_out_mem(rsp_out_mem),
        .rsp_out_loc(rsp_out_loc), .rsp_out_val(rsp_out_val));

    task automatic check(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Stage an insert (one reg input slot, optional second slot) for the next cycle
    task automatic stage_ins(logic [15:0] pc, logic [15:0] nxt, logic [5:0] l0, logic [15:0] v0,
                             logic m1, logic [5:0] l1, logic [15:0] v1, logic [15:0] ov);
        ins_en = 1; ins_pc = pc; ins_next_pc = nxt;
        ins_in_used = 2'b11; ins_in_mem = {m1, 1'b0};
        ins_in_loc[0] = l0; ins_in_val[0] = v0; ins_in_loc[1] = l1; ins_in_val[1] = v1;
        ins_out_used = 2'b01; ins_out_mem = 2'b00;
        ins_out_loc[0] = 6'd5; ins_out_val[0] = ov; ins_out_loc[1] = '0; ins_out_val[1] = '0;
    endtask

    task automatic stage_wr(logic m, logic [5:0] l, logic [15:0] v);
        wr_en = 1; wr_is_mem = m; wr_loc = l; wr_val = v;
    endtask

    // advance one cycle, then drop all strobes
    task automatic step();
        @(negedge clk);
        ins_en = 0; wr_en = 0; lk_en = 0;
    endtask

    task automatic insert(logic [15:0] pc, logic [15:0] nxt, logic [5:0] l0, logic [15:0] v0);
        @(negedge clk);
        stage_ins(pc, nxt, l0, v0, 1'b1, 6'd32, 16'h2222, nxt ^ 16'h00FF);
        step();
    endtask

    task automatic write(logic m, logic [5:0] l, logic [15:0] v);
        @(negedge clk);
        stage_wr(m, l, v);
        step();
    endtask

    task automatic lookup(string req, logic [15:0] pc, bit exp_hit, logic [1:0] exp_way,
                          logic [15:0] exp_nxt);
        @(negedge clk);
        lk_en = 1; lk_pc = pc;
        step();
        check(req, "hit", rsp_hit, exp_hit);
        if (exp_hit) begin
            check(req, "way", rsp_way, exp_way);
            check(req, "next_pc", rsp_next_pc, exp_nxt);
        end else begin
            check(req, "next_pc zero on miss", rsp_next_pc, 0);
        end
    endtask

    task automatic t_reset();
        check("R1", "hit after reset", rsp_hit, 0);
        lookup("R1", 16'h0010, 0, 0, 0);
        lookup("R9", 16'h0000, 0, 0, 0);
    endtask

    task automatic t_basic();
        insert(16'h0104, 16'h0200, 6'd3, 16'h0011);
        lookup("R2", 16'h0104, 1, 2'd0, 16'h0200);
        check("R2", "out_used", rsp_out_used, 2'b01);
        check("R2", "out_loc0", rsp_out_loc[0], 5);
        check("R2", "out_val0", rsp_out_val[0], 16'h02FF);
        step();
        check("R9", "hit held after lookup", rsp_hit, 0);
        check("R9", "out_val cleared", rsp_out_val[0], 0);
        lookup("R3", 16'h0204, 0, 0, 0);
    endtask

    task automatic t_snoop_bit();
        write(1'b0, 6'd4, 16'h0011);
        lookup("R5", 16'h0104, 1, 2'd0, 16'h0200);
        write(1'b1, 6'd3, 16'h0099);
        lookup("R5", 16'h0104, 1, 2'd0, 16'h0200);
        write(1'b0, 6'd3, 16'h0011);
        lookup("R5", 16'h0104, 0, 0, 0);
    endtask

    task automatic t_same_cycle();
        insert(16'h0104, 16'h0200, 6'd3, 16'h0011);
        @(negedge clk);
        lk_en = 1; lk_pc = 16'h0104;
        stage_wr(1'b1, 6'd32, 16'h0000);
        step();
        check("R6", "lookup during kill", rsp_hit, 0);
        lookup("R6", 16'h0104, 0, 0, 0);
    endtask

    task automatic t_multi();
        insert(16'h0011, 16'h0300, 6'd7, 16'h0001);
        insert(16'h0011, 16'h0301, 6'd8, 16'h0001);
        lookup("R4", 16'h0011, 1, 2'd0, 16'h0300);
        write(1'b0, 6'd7, 16'h0002);
        lookup("R4", 16'h0011, 1, 2'd1, 16'h0301);
    endtask

    task automatic t_lru();
        insert(16'h0022, 16'h0400, 6'd10, 16'h0);
        insert(16'h0026, 16'h0401, 6'd10, 16'h0);
        insert(16'h002A, 16'h0402, 6'd10, 16'h0);
        insert(16'h002E, 16'h0403, 6'd10, 16'h0);
        lookup("R8", 16'h0022, 1, 2'd0, 16'h0400);
        insert(16'h0032, 16'h0404, 6'd10, 16'h0);
        lookup("R8", 16'h0032, 1, 2'd1, 16'h0404);
        lookup("R8", 16'h0026, 0, 0, 0);
        lookup("R8", 16'h002A, 1, 2'd2, 16'h0402);
    endtask

    task automatic t_value_mode();
        test_mode = 1;
        insert(16'h0043, 16'h0500, 6'd9, 16'h0055);
        write(1'b0, 6'd9, 16'h0055);
        lookup("R7", 16'h0043, 1, 2'd0, 16'h0500);
        write(1'b0, 6'd9, 16'h0056);
        lookup("R7", 16'h0043, 0, 0, 0);
        write(1'b0, 6'd9, 16'h0055);
        lookup("R7", 16'h0043, 1, 2'd0, 16'h0500);
        test_mode = 0;
    endtask

    task automatic t_insert_snoop();
        @(negedge clk);
        stage_ins(16'h0308, 16'h0600, 6'd12, 16'h0077, 1'b1, 6'd33, 16'h0, 16'h0);
        stage_wr(1'b0, 6'd12, 16'h0078);
        step();
        lookup("R10", 16'h0308, 1, 2'd0, 16'h0600);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_snoop_bit();
        t_same_cycle();
        t_multi();
        t_lru();
        t_value_mode();
        t_insert_snoop();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule